// File: doc/BRIEF.md
# Software Standby Entry and Wake Sequencer

This block sequences a small processor subsystem into and out of a low-power standby state. When the CPU signals that it has executed its wait instruction, the sequencer checks its control bits and the state of the rest of the system. If entry is allowed, it holds or floats the external bus for one cycle. It then turns off the CPU clock enable, the peripheral clock enable and the oscillator enable. While the system is parked, nothing is reset. Register, memory and port contents stay as they are, because the block simply withholds clocks.

Wake-up comes from the interrupt requests. A request counts only when its per-source enable is set and its priority is strictly above the CPU's current mask level. On wake, the oscillator is restarted first. A settling count, advanced by strobes from an always-on slow time base, must run out before the CPU and peripheral clocks return. A wake request that arrives during the one-cycle bus-settle step cancels the entry, and no clock is ever gated. A failed entry attempt leaves the system running and sets a sticky error flag, which stays set until it is cleared by a register write strobe.

Top module: `stby_wake_ctrl`

## Requirements
- R1: A wait strobe is acted on only in state RUN (`pm_state`=0) with `sel_standby`=1 and `sel_deep`=0. With all entry preconditions met, the next state is ENTER (`pm_state`=1). With `sel_standby`=0 or `sel_deep`=1, the strobe is ignored: the state stays RUN and no error is raised.
- R2: In STANDBY (`pm_state`=2), `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. In RUN and ENTER they are all 1.
- R3: From ENTER through OSC_SETTLE, the bus control follows `bus_hold_mode` as sampled at the accepted wait strobe. A value of 0 gives `bus_hiz`=1 and `bus_hold`=0. A value of 1 gives `bus_hiz`=0 and `bus_hold`=1. In RUN both are 0.
- R4: If `wdt_wd_active`=1 when an otherwise valid wait strobe arrives, the block stays in RUN and sets `entry_err`.
- R5: Entry also requires `iclk_div`==`pclk_div`, `dma_run`=0 and `xfer_run`=0. If any of these fails, the block stays in RUN and sets `entry_err`.
- R6: A source i is a wake source only when `irq_req[i]`=1, `irq_en[i]`=1 and its priority field `irq_prio[i*PW +: PW]` is strictly greater than `cpu_mask`. A request with priority equal to the mask, or with its enable cleared, leaves the block in STANDBY.
- R7: `ie_set_pulse` is high for exactly the one cycle spent in ENTER.
- R8: `entry_err` stays set until an `err_clr` strobe. If a new fault and a clear occur in the same cycle, the flag is set.
- R9: A wake in STANDBY moves the block to OSC_SETTLE (`pm_state`=3) with `osc_en`=1 and the CPU and peripheral clock enables at 0. The counter loads `settle_val` and counts down by one on each `slow_tick`. One cycle after it reaches zero, the block returns to RUN with all clocks enabled. With `slow_tick` held at 1, this is `settle_val`+1 cycles after the wake edge.
- R10: A wake request present while in ENTER returns the block to RUN without ever deasserting a clock enable.
- R11: After reset the block is in RUN with all clock enables at 1, both bus controls at 0, `ie_set_pulse`=0 and `entry_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on system clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_stb | input | 1 | One-cycle strobe: CPU executed its wait instruction |
| sel_standby | input | 1 | Standby select control bit |
| sel_deep | input | 1 | Deep-standby select control bit (blocks this mode) |
| bus_hold_mode | input | 1 | 0: float bus in standby, 1: hold last values |
| wdt_wd_active | input | 1 | Watchdog running in watchdog mode |
| dma_run | input | 1 | DMA controller start bit |
| xfer_run | input | 1 | Transfer controller start bit |
| iclk_div | input | DIVW | System clock divider setting |
| pclk_div | input | DIVW | Peripheral clock divider setting |
| irq_req | input | NSRC | Interrupt request lines |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_prio | input | NSRC*PW | Packed per-source priorities |
| cpu_mask | input | PW | CPU current priority mask level |
| settle_val | input | CNTW | Oscillator settling count |
| slow_tick | input | 1 | Strobe from the always-on slow time base |
| err_clr | input | 1 | Register write strobe clearing the error flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_hiz | output | 1 | Drive address bus and bus controls high-impedance |
| bus_hold | output | 1 | Freeze address bus and bus controls at last values |
| ie_set_pulse | output | 1 | One-cycle request to set the CPU interrupt-enable flag |
| entry_err | output | 1 | Sticky failed-entry flag |
| pm_state | output | 2 | Sequencer state: 0 RUN, 1 ENTER, 2 STANDBY, 3 OSC_SETTLE |

## Verification
A table of entry attempts covers each precondition alone. These rows are: unequal dividers, DMA running, transfer engine running and watchdog active, plus the two select-bit cases that must be ignored silently. Together they separate the faults that raise the error flag from the configurations that are merely not a standby request. The wake qualifier is tried with three requests. One has priority equal to the mask, one has a high priority but its enable cleared, and one has a strictly higher priority. This shows that the comparison is strict and that it is gated by the enable. Settling is timed with the tick held high, giving an exact cycle count, and with the tick held low, showing that the count stalls. The abort case sends a wake request together with the wait strobe, which shows that ENTER never gates a clock.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_ENTER  = 2'd1,
    PM_STBY   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_t;
endpackage

// File: rtl/stby_entry_check.sv
// Combines the independent conditions that must all hold before standby entry.
module stby_entry_check #(
  parameter int DIVW = 3
) (
  input  logic            wdt_wd_active,
  input  logic            dma_run,
  input  logic            xfer_run,
  input  logic [DIVW-1:0] iclk_div,
  input  logic [DIVW-1:0] pclk_div,
  output logic            entry_ok
);
  logic div_match;
  logic engines_idle;

  always_comb begin
    div_match    = (iclk_div == pclk_div);
    engines_idle = ~dma_run & ~xfer_run;
    entry_ok     = div_match & engines_idle & ~wdt_wd_active;
  end
endmodule

// File: rtl/stby_wake_qual.sv
// Per-source qualification: enabled and strictly above the CPU mask.
module stby_wake_qual #(
  parameter int NSRC = 8,
  parameter int PW   = 3
) (
  input  logic [NSRC-1:0]    irq_req,
  input  logic [NSRC-1:0]    irq_en,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic [PW-1:0]      cpu_mask,
  output logic               wake
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = irq_req[g] & irq_en[g] & (irq_prio[g*PW +: PW] > cpu_mask);
  end

  assign wake = |hit;
endmodule

// File: rtl/stby_settle_cnt.sv
// Oscillator settling down-counter advanced by always-on slow-tick strobes.
module stby_settle_cnt #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            tick,
  output logic            expired
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  parameter int DIVW = 3,
  parameter int CNTW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wait_stb,
  input  logic               sel_standby,
  input  logic               sel_deep,
  input  logic               bus_hold_mode,
  input  logic               wdt_wd_active,
  input  logic               dma_run,
  input  logic               xfer_run,
  input  logic [DIVW-1:0]    iclk_div,
  input  logic [DIVW-1:0]    pclk_div,
  input  logic [NSRC-1:0]    irq_req,
  input  logic [NSRC-1:0]    irq_en,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic [PW-1:0]      cpu_mask,
  input  logic [CNTW-1:0]    settle_val,
  input  logic               slow_tick,
  input  logic               err_clr,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic               bus_hiz,
  output logic               bus_hold,
  output logic               ie_set_pulse,
  output logic               entry_err,
  output logic [1:0]         pm_state
);
  pm_state_t st_q, st_n;
  logic      entry_ok, wake, settle_done;
  logic      req_valid, accept, fault, load_cnt;
  logic      mode_q, mode_n;
  logic      gate_core, gate_osc, bus_ctl;

  stby_entry_check #(.DIVW(DIVW)) u_check (
    .wdt_wd_active(wdt_wd_active),
    .dma_run      (dma_run),
    .xfer_run     (xfer_run),
    .iclk_div     (iclk_div),
    .pclk_div     (pclk_div),
    .entry_ok     (entry_ok)
  );

  stby_wake_qual #(.NSRC(NSRC), .PW(PW)) u_qual (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .irq_prio(irq_prio),
    .cpu_mask(cpu_mask),
    .wake    (wake)
  );

  stby_settle_cnt #(.CNTW(CNTW)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .load    (load_cnt),
    .load_val(settle_val),
    .tick    (slow_tick),
    .expired (settle_done)
  );

  always_comb begin
    req_valid = (st_q == PM_RUN) & wait_stb & sel_standby & ~sel_deep;
    accept    = req_valid & entry_ok;
    fault     = req_valid & ~entry_ok;
    load_cnt  = (st_q == PM_STBY) & wake;
    mode_n    = accept ? bus_hold_mode : mode_q;

    st_n = st_q;
    unique case (st_q)
      PM_RUN:    if (accept)      st_n = PM_ENTER;
      PM_ENTER:  st_n = wake ? PM_RUN : PM_STBY;
      PM_STBY:   if (wake)        st_n = PM_SETTLE;
      PM_SETTLE: if (settle_done) st_n = PM_RUN;
      default:   st_n = PM_RUN;
    endcase

    gate_core = (st_n == PM_STBY) | (st_n == PM_SETTLE);
    gate_osc  = (st_n == PM_STBY);
    bus_ctl   = (st_n != PM_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= PM_RUN;
      mode_q       <= 1'b0;
      cpu_clk_en   <= 1'b1;
      per_clk_en   <= 1'b1;
      osc_en       <= 1'b1;
      bus_hiz      <= 1'b0;
      bus_hold     <= 1'b0;
      ie_set_pulse <= 1'b0;
      entry_err    <= 1'b0;
    end else begin
      st_q         <= st_n;
      mode_q       <= mode_n;
      cpu_clk_en   <= ~gate_core;
      per_clk_en   <= ~gate_core;
      osc_en       <= ~gate_osc;
      bus_hiz      <= bus_ctl & ~mode_n;
      bus_hold     <= bus_ctl & mode_n;
      ie_set_pulse <= accept;
      if (fault)        entry_err <= 1'b1;
      else if (err_clr) entry_err <= 1'b0;
    end
  end

  assign pm_state = st_q;
endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wait_stb,
  input logic       sel_standby,
  input logic       sel_deep,
  input logic [1:0] pm_state,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       bus_hiz,
  input logic       bus_hold,
  input logic       ie_set_pulse,
  input logic       entry_err
);
  p_entry_cond_r1: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd1) |-> ($past(wait_stb) && $past(sel_standby) && !$past(sel_deep)));

  p_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd2) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

  p_bus_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (pm_state != 2'd0) |-> (bus_hiz ^ bus_hold));

  p_stby_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd2) |=> (pm_state == 2'd2 || pm_state == 2'd3));

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (rst)
    ie_set_pulse |=> !ie_set_pulse);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(entry_err) |-> $past(wait_stb));

  p_settle_osc_r9: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd3) |-> (osc_en && !cpu_clk_en && !per_clk_en));

  p_enter_next_r10: assert property (@(posedge clk) disable iff (rst)
    (pm_state == 2'd1) |=> (pm_state == 2'd0 || pm_state == 2'd2));
endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wait_stb    (wait_stb),
  .sel_standby (sel_standby),
  .sel_deep    (sel_deep),
  .pm_state    (pm_state),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .osc_en      (osc_en),
  .bus_hiz     (bus_hiz),
  .bus_hold    (bus_hold),
  .ie_set_pulse(ie_set_pulse),
  .entry_err   (entry_err)
);

// File: tb/stby_wake_ctrl_test.sv
`timescale 1ns/1ps
module stby_wake_ctrl_test;
  localparam int NSRC = 8, PW = 3, DIVW = 3, CNTW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_stb = 0, sel_standby = 0, sel_deep = 0, bus_hold_mode = 0;
  logic wdt_wd_active = 0, dma_run = 0, xfer_run = 0;
  logic [DIVW-1:0] iclk_div = 0, pclk_div = 0;
  logic [NSRC-1:0] irq_req = 0, irq_en = '1;
  logic [NSRC*PW-1:0] irq_prio;
  logic [PW-1:0] cpu_mask = 3'd3;
  logic [CNTW-1:0] settle_val = 8'd2;
  logic slow_tick = 1, err_clr = 0;
  logic cpu_clk_en, per_clk_en, osc_en, bus_hiz, bus_hold, ie_set_pulse, entry_err;
  logic [1:0] pm_state;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  stby_wake_ctrl #(.NSRC(NSRC), .PW(PW), .DIVW(DIVW), .CNTW(CNTW)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Issue a wait strobe; returns at the negedge after the accepting edge.
  task automatic do_wait();
    wait_stb = 1;
    step(1);
    wait_stb = 0;
  endtask

  // Wake via source 4 (priority 4 > mask 3) and wait for RUN.
  task automatic wake_to_run();
    irq_req = 8'h10;
    step(1);
    irq_req = 0;
    for (int i = 0; i < 600 && pm_state != 2'd0; i++) step(1);
  endtask

  // Vector fields: {sel_sb, sel_deep, wdt, dma, xfer, div_diff, exp_enter, exp_err}
  localparam logic [7:0] VEC [8] = '{
    8'b1_0_0_0_0_0_1_0,
    8'b0_0_0_0_0_0_0_0,
    8'b1_1_0_0_0_0_0_0,
    8'b1_0_1_0_0_0_0_1,
    8'b1_0_0_1_0_0_0_1,
    8'b1_0_0_0_1_0_0_1,
    8'b1_0_0_0_0_1_0_1,
    8'b1_1_1_1_1_1_0_0
  };

  initial begin
    for (int k = 0; k < NSRC; k++) irq_prio[k*PW +: PW] = PW'(k);
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R11 reset state
    chk("R11 state", pm_state, 0);
    chk("R11 clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R11 bus", {bus_hiz, bus_hold}, 0);
    chk("R11 flags", {ie_set_pulse, entry_err}, 0);

    // Table walk: R1, R4, R5
    for (int v = 0; v < 8; v++) begin
      sel_standby   = VEC[v][7];
      sel_deep      = VEC[v][6];
      wdt_wd_active = VEC[v][5];
      dma_run       = VEC[v][4];
      xfer_run      = VEC[v][3];
      pclk_div      = VEC[v][2] ? 3'd2 : 3'd0;
      err_clr = 1; step(1); err_clr = 0;
      do_wait();
      chk($sformatf("R1/R4/R5 vec%0d state", v), pm_state, VEC[v][1] ? 1 : 0);
      chk($sformatf("R4/R5 vec%0d err", v), entry_err, VEC[v][0]);
      if (VEC[v][1]) begin
        step(1);
        wake_to_run();
      end
      step(2);
    end
    sel_standby = 1; sel_deep = 0; wdt_wd_active = 0; dma_run = 0; xfer_run = 0; pclk_div = 0;

    // R8 sticky and clear; set wins over clear
    wdt_wd_active = 1; do_wait(); wdt_wd_active = 0;
    step(5);
    chk("R8 sticky", entry_err, 1);
    err_clr = 1; step(1); err_clr = 0;
    chk("R8 cleared", entry_err, 0);
    wdt_wd_active = 1; err_clr = 1; do_wait(); wdt_wd_active = 0; err_clr = 0;
    chk("R8 set beats clear", entry_err, 1);
    err_clr = 1; step(1); err_clr = 0;

    // Full entry, float mode: R7, R3, R2
    bus_hold_mode = 0;
    do_wait();
    chk("R7 pulse in ENTER", ie_set_pulse, 1);
    chk("R3 hiz in ENTER", {bus_hiz, bus_hold}, 2'b10);
    chk("R2 clocks on in ENTER", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    bus_hold_mode = 1;  // changes after sampling must not matter
    step(1);
    chk("R2 standby state", pm_state, 2);
    chk("R2 all gated", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
    chk("R7 pulse ends", ie_set_pulse, 0);
    chk("R3 hiz held sample", {bus_hiz, bus_hold}, 2'b10);

    // R6: equal priority and disabled source do not wake
    irq_req = 8'h08; step(3);
    chk("R6 equal prio no wake", pm_state, 2);
    irq_en = 8'h7F; irq_req = 8'h80; step(3);
    chk("R6 disabled no wake", pm_state, 2);
    irq_en = '1;

    // R9: settle timing with settle_val=3, tick always on
    settle_val = 3;
    irq_req = 8'h10; step(1); irq_req = 0;
    chk("R9 settle state", pm_state, 3);
    chk("R9 osc first", {osc_en, cpu_clk_en, per_clk_en}, 3'b100);
    step(3);
    chk("R9 still settling", pm_state, 3);
    step(1);
    chk("R9 back to run", pm_state, 0);
    chk("R9 clocks back", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R3 bus released", {bus_hiz, bus_hold}, 0);

    // Hold mode plus stalled tick
    bus_hold_mode = 1;
    do_wait(); step(1);
    chk("R3 hold in standby", {bus_hiz, bus_hold}, 2'b01);
    slow_tick = 0; settle_val = 1;
    irq_req = 8'h10; step(1); irq_req = 0;
    step(10);
    chk("R9 stalls without tick", pm_state, 3);
    slow_tick = 1; step(2);
    chk("R9 resumes with tick", pm_state, 0);

    // R10 abort: wake present with wait strobe
    bus_hold_mode = 0;
    irq_req = 8'h10;
    do_wait();
    chk("R10 enter", pm_state, 1);
    step(1);
    chk("R10 abort to run", pm_state, 0);
    chk("R10 clocks never off", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    irq_req = 0;

    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule